// File: doc/BRIEF.md
# SMBus Indexed Register Target for Clock-Buffer Control

This block is a serial-bus target that holds the control bytes of a multi-output clock buffer. A host reaches the bank through indexed block transactions. A write carries a starting index, a byte count and that many data bytes. A read first sets the index with a write header, then turns the bus round with a repeated start. The target answers with a length byte, followed by register contents from the index onward. The number of bytes a read returns is held in a register that the host can write.

The serial clock and data lines arrive already synchronised to a fast system clock. The block finds start, stop and the clock edges by comparing each sample with the one before. It pulls the data line low through a single open-drain enable. The stored control fields leave the block as parallel ports for the output-control logic: power-down float, stop float, low loop bandwidth, PLL mode, full-rate select, the per-output enables and the per-output stoppable flags. The programmed read length is also a port.

Top module: `smb_clkctl_regs`

## Requirements
- R1: The target acknowledges only the address bytes 0xDC (write) and 0xDD (read). Any other address byte leaves the data line released in the acknowledge slot, and the rest of the transaction is ignored until the next start.
- R2: A block write is start, 0xDC, index N, count X, then X data bytes. Each of these bytes is acknowledged. Data byte k is stored at index N+k.
- R3: After X data bytes, any further data byte in the same write is not acknowledged and is not stored.
- R4: A block read is start, 0xDC, index N, repeated start, 0xDD. The target first returns the read length held at index 6, then that many bytes starting at index N. Any byte the host asks for after those returns 0xFF.
- R5: When the host does not acknowledge a byte the target has sent, the target releases the data line before the next clock high and ends the transaction.
- R6: Reset values: index 0 = 0x07, index 1 = 0xFF, index 2 = 0x00, index 6 = 0x07. The ports decode index 0 as bit 7 power-down float, bit 6 stop float, bit 2 low bandwidth, bit 1 PLL mode and bit 0 full rate. Index 1 drives out_en, index 2 drives out_stoppable and index 6 drives read_len.
- R7: Index 4 reads {REV_ID, 4'b0001} and index 5 reads DEV_ID, and writes to either leave them unchanged. Bits 5:3 of index 0 always read 0.
- R8: Index 3 and indices 7 and above read 0x00, and writes to them change no register.
- R9: A start or stop received part way through a byte aborts the transaction. Registers stored by earlier, complete bytes keep their values, and the partial byte is not stored.
- R10: The target changes the data line only while the clock is low. Its acknowledge is held low for exactly one clock high period, the ninth of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (line level) |
| sda_oe | output | 1 | Pull the data line low when 1 |
| pd_float | output | 1 | Power-down drive: 1 = outputs float |
| stop_float | output | 1 | Stop drive: 1 = stopped outputs float |
| bw_low | output | 1 | 1 = low PLL bandwidth |
| pll_mode | output | 1 | 1 = PLL mode, 0 = fan-out bypass |
| full_rate | output | 1 | 1 = input rate, 0 = divide by 2 |
| out_en | output | 8 | Per-output enable, 1 = enabled |
| out_stoppable | output | 8 | Per-output stop behaviour, 1 = stoppable |
| read_len | output | 8 | Programmed block-read length |

## Verification
The hardest state to reach from the ports is an abort in the middle of a byte. The host model must break off its bit loop at a chosen bit and raise or lower data while the clock is high. Only then can the bench confirm that registers from earlier bytes survive and the partial byte is lost. The other hard case is the tail of a read, where the host keeps acknowledging past the programmed length. The bench sweeps the read length from 0 to 9 so that every split between real data and the 0xFF fill is seen, and it sweeps all 256 address bytes for the acknowledge rule.

// File: rtl/smb_clkctl_pkg.sv
package smb_clkctl_pkg;

  localparam int DW       = 8;
  localparam int NREG     = 8;
  localparam int IDX_MODE = 0;
  localparam int IDX_OE   = 1;
  localparam int IDX_STP  = 2;
  localparam int IDX_VID  = 4;
  localparam int IDX_DID  = 5;
  localparam int IDX_LEN  = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_INDEX, S_COUNT, S_WDATA, S_RBYTE
  } smb_st_e;

  function automatic logic [DW-1:0] addr_byte(input logic [6:0] a7, input logic rd);
    return {a7, rd};
  endfunction

  function automatic logic [DW-1:0] next_index(input logic [DW-1:0] idx);
    return idx + 8'd1;
  endfunction

  // Which bits of each index the host may change.
  function automatic logic [DW-1:0] reg_wmask(input int i);
    case (i)
      IDX_MODE:        return 8'hC7;
      IDX_OE, IDX_STP: return 8'hFF;
      IDX_LEN:         return 8'hFF;
      default:         return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_init(input int i, input logic [3:0] rev,
                                             input logic [DW-1:0] dev);
    case (i)
      IDX_MODE: return 8'h07;
      IDX_OE:   return 8'hFF;
      IDX_STP:  return 8'h00;
      IDX_VID:  return {rev, 4'b0001};
      IDX_DID:  return dev;
      IDX_LEN:  return 8'h07;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = !scl_q && scl_i;
  assign scl_fall  = scl_q && !scl_i;
  assign start_evt = scl_q && scl_i && sda_q && !sda_i;
  assign stop_evt  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_clkctl_pkg::*;
#(
  parameter logic [3:0]    REV_ID = 4'h0,
  parameter logic [DW-1:0] DEV_ID = 8'h81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] oe_q,
  output logic [DW-1:0] stp_q,
  output logic [DW-1:0] len_q
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = reg_wmask(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[i] <= reg_init(i, REV_ID, DEV_ID);
      else if (wr_en && (wr_idx == DW'(i)))
        bank[i] <= (bank[i] & ~MASK) | (wr_data & MASK);
    end
  end

  assign rd_data = (rd_idx < DW'(NREG)) ? bank[rd_idx[IW-1:0]] : '0;
  assign mode_q  = bank[IDX_MODE];
  assign oe_q    = bank[IDX_OE];
  assign stp_q   = bank[IDX_STP];
  assign len_q   = bank[IDX_LEN];

  // Without a write strobe from the engine the control outputs hold.
  p_bank_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_q) && $stable(oe_q) && $stable(stp_q) && $stable(len_q)));
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_clkctl_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h6E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] len_i,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [DW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_idx
);
  localparam logic [DW-1:0] WR_BYTE = addr_byte(ADDR7, 1'b0);
  localparam logic [DW-1:0] RD_BYTE = addr_byte(ADDR7, 1'b1);
  localparam logic [3:0]    NBITS   = 4'(DW);

  smb_st_e       st, st_next;
  logic [3:0]    bcnt;
  logic [DW-1:0] shreg, idx, wleft, rleft;
  logic          rx_ack, tx_ack, host_ack, oe_q;
  logic          rx_state, byte_done, ack_this, addr_bad_evt;

  assign rx_state  = (st == S_ADDR) || (st == S_INDEX) || (st == S_COUNT) || (st == S_WDATA);
  assign byte_done = rx_state && !rx_ack && scl_fall && (bcnt == NBITS);

  always_comb begin
    ack_this = 1'b0;
    st_next  = st;
    case (st)
      S_ADDR: begin
        ack_this = (shreg == WR_BYTE) || (shreg == RD_BYTE);
        st_next  = (shreg == RD_BYTE) ? S_RBYTE : S_INDEX;
      end
      S_INDEX: begin ack_this = 1'b1; st_next = S_COUNT; end
      S_COUNT: begin ack_this = 1'b1; st_next = S_WDATA; end
      S_WDATA: begin ack_this = (wleft != '0); st_next = S_WDATA; end
      default: ;
    endcase
  end

  assign wr_en        = byte_done && (st == S_WDATA) && (wleft != '0);
  assign wr_idx       = idx;
  assign wr_data      = shreg;
  assign rd_idx       = idx;
  assign addr_bad_evt = byte_done && (st == S_ADDR) && !ack_this;
  assign sda_oe       = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; shreg <= '0; idx <= '0; wleft <= '0; rleft <= '0;
      rx_ack <= 1'b0; tx_ack <= 1'b0; host_ack <= 1'b0; oe_q <= 1'b0;
    end else if (start_evt || stop_evt) begin
      st     <= start_evt ? S_ADDR : S_IDLE;
      bcnt   <= '0;
      rx_ack <= 1'b0;
      tx_ack <= 1'b0;
      oe_q   <= 1'b0;
    end else if (rx_ack) begin
      // End of the acknowledge we are driving.
      if (scl_fall) begin
        rx_ack <= 1'b0;
        bcnt   <= '0;
        if (st == S_RBYTE) begin
          shreg <= len_i;
          rleft <= len_i;
          oe_q  <= ~len_i[DW-1];
        end else begin
          oe_q <= 1'b0;
        end
      end
    end else if (rx_state) begin
      if (scl_rise && (bcnt != NBITS)) begin
        shreg <= {shreg[DW-2:0], sda_i};
        bcnt  <= bcnt + 4'd1;
      end
      if (byte_done) begin
        if (ack_this) begin
          rx_ack <= 1'b1;
          oe_q   <= 1'b1;
          st     <= st_next;
        end else begin
          st   <= S_IDLE;
          bcnt <= '0;
        end
        if (st == S_INDEX) idx   <= shreg;
        if (st == S_COUNT) wleft <= shreg;
        if (wr_en) begin
          idx   <= next_index(idx);
          wleft <= wleft - 8'd1;
        end
      end
    end else if (st == S_RBYTE) begin
      if (tx_ack) begin
        if (scl_rise) host_ack <= ~sda_i;
        if (scl_fall) begin
          tx_ack <= 1'b0;
          bcnt   <= '0;
          if (host_ack) begin
            if (rleft != '0) begin
              shreg <= rd_data;
              oe_q  <= ~rd_data[DW-1];
              idx   <= next_index(idx);
              rleft <= rleft - 8'd1;
            end else begin
              shreg <= '1;
              oe_q  <= 1'b0;
            end
          end else begin
            st   <= S_IDLE;
            oe_q <= 1'b0;
          end
        end
      end else begin
        if (scl_rise && (bcnt != NBITS)) bcnt <= bcnt + 4'd1;
        if (scl_fall) begin
          if (bcnt == NBITS) begin
            oe_q   <= 1'b0;
            tx_ack <= 1'b1;
          end else if (bcnt != '0) begin
            shreg <= {shreg[DW-2:0], 1'b1};
            oe_q  <= ~shreg[DW-2];
          end
        end
      end
    end
  end

  p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
  p_write_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);
  p_bad_addr_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bad_evt |=> !sda_oe);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
endmodule

// File: rtl/smb_clkctl_regs.sv
module smb_clkctl_regs
  import smb_clkctl_pkg::*;
#(
  parameter logic [6:0]    ADDR7  = 7'h6E,
  parameter logic [3:0]    REV_ID = 4'h0,
  parameter logic [DW-1:0] DEV_ID = 8'h81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          pd_float,
  output logic          stop_float,
  output logic          bw_low,
  output logic          pll_mode,
  output logic          full_rate,
  output logic [DW-1:0] out_en,
  output logic [DW-1:0] out_stoppable,
  output logic [DW-1:0] read_len
);
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [DW-1:0] wr_idx, wr_data, rd_idx, rd_data, mode_q;

  smb_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_engine #(.ADDR7(ADDR7)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .len_i(read_len), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx)
  );

  smb_regbank #(.REV_ID(REV_ID), .DEV_ID(DEV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .mode_q(mode_q), .oe_q(out_en),
    .stp_q(out_stoppable), .len_q(read_len)
  );

  assign pd_float   = mode_q[7];
  assign stop_float = mode_q[6];
  assign bw_low     = mode_q[2];
  assign pll_mode   = mode_q[1];
  assign full_rate  = mode_q[0];
endmodule

// File: tb/smb_clkctl_regs_tb.sv
module smb_clkctl_regs_tb;
  localparam int Q = 5;
  localparam logic [3:0] REV = 4'h3;
  localparam logic [7:0] DEV = 8'h81;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic sda_oe, pd_float, stop_float, bw_low, pll_mode, full_rate;
  logic [7:0] out_en, out_stoppable, read_len;
  wire sda_line = sda_h & ~sda_oe;

  int n_chk = 0, n_fail = 0, viol = 0;
  bit done = 0;
  logic [7:0] model [8];
  logic [7:0] rbuf [16];
  logic [7:0] wbuf [16];
  logic       abuf [16];
  logic       last_rel;

  always #10 clk = ~clk;

  smb_clkctl_regs #(.REV_ID(REV), .DEV_ID(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pd_float(pd_float), .stop_float(stop_float), .bw_low(bw_low),
    .pll_mode(pll_mode), .full_rate(full_rate), .out_en(out_en),
    .out_stoppable(out_stoppable), .read_len(read_len)
  );

  // R10 monitor: target drive must not move while the clock stays high.
  logic p_scl = 1'b1, p_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && p_scl && (sda_oe != p_oe)) viol++;
    p_scl <= scl;
    p_oe  <= sda_oe;
  end

  function automatic logic [7:0] bmask(int i);
    if (i == 0) return 8'b1100_0111;
    if (i == 1 || i == 2 || i == 6) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_line;
    scl = 1'b0; tick(Q);
    last_rel = sda_line;
  endtask

  task automatic rd_byte(logic give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; scl = 1'b0;
    end
    tick(Q); sda_h = ~give_ack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(1); sda_h = 1'b1;
  endtask

  task automatic block_write(logic [7:0] idx, logic [7:0] cnt, int nsend);
    logic a;
    bus_start();
    wr_byte(8'hDC, abuf[0]);
    wr_byte(idx, abuf[1]);
    wr_byte(cnt, abuf[2]);
    for (int k = 0; k < nsend; k++) begin
      wr_byte(wbuf[k], a);
      abuf[3 + k] = a;
      if (a && idx + k < 8) begin
        int j = idx + k;
        model[j] = (model[j] & ~bmask(j)) | (wbuf[k] & bmask(j));
      end
    end
    bus_stop();
  endtask

  task automatic block_read(logic [7:0] idx, int n);
    logic a;
    bus_start();
    wr_byte(8'hDC, a);
    wr_byte(idx, a);
    bus_start();
    wr_byte(8'hDD, a);
    rd_byte(n != 0, rbuf[0]);
    for (int k = 1; k <= n; k++) rd_byte(k != n, rbuf[k]);
    tick(Q);
    check("R5 line released after host nack", {7'd0, sda_line}, 8'h01);
    bus_stop();
  endtask

  task automatic check_ports(string tag);
    check({tag, " mode"}, {pd_float, stop_float, 3'b000, bw_low, pll_mode, full_rate}, model[0]);
    check({tag, " out_en"}, out_en, model[1]);
    check({tag, " out_stoppable"}, out_stoppable, model[2]);
    check({tag, " read_len"}, read_len, model[6]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    model[0] = 8'h07; model[1] = 8'hFF; model[6] = 8'h07;
    model[4] = {REV, 4'b0001}; model[5] = DEV;
    tick(4); rst_n = 1'b1; tick(4);

    // R6 reset values at the ports
    check_ports("R6 reset");
    check("R6 sda released at reset", {7'd0, sda_oe}, 8'h00);

    // R1 sweep of all address bytes
    for (int ad = 0; ad < 256; ad++) begin
      bus_start();
      wr_byte(8'(ad), a);
      if (ad == 8'hDD) rd_byte(1'b0, b);
      bus_stop();
      check("R1 address ack", {7'd0, a}, (ad == 8'hDC || ad == 8'hDD) ? 8'h01 : 8'h00);
    end

    // R2 write sweep over patterns to indices 1 and 2
    for (int k = 0; k < 8; k++) begin
      wbuf[0] = 8'h01 << k ^ 8'h5A;
      wbuf[1] = ~(8'h80 >> k);
      block_write(8'd1, 8'd2, 2);
      for (int j = 0; j < 5; j++) check("R2 byte ack", {7'd0, abuf[j]}, 8'h01);
      check("R10 line released after ack", {7'd0, last_rel}, 8'h01);
      check_ports("R2 after write");
    end

    // R7 read-only and reserved bits
    wbuf[0] = 8'hFF;
    block_write(8'd0, 8'd1, 1);
    check("R7 reserved bits of mode read zero", {pd_float, stop_float, 3'b000, bw_low, pll_mode, full_rate}, 8'hC7);
    wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
    block_write(8'd4, 8'd2, 2);
    // R8 unimplemented indices
    wbuf[0] = 8'hE1;
    block_write(8'd3, 8'd1, 1);
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    block_write(8'd7, 8'd2, 2);
    check_ports("R8 after discarded writes");

    // R4 read length sweep, including the 0xFF tail
    for (int len = 0; len < 10; len++) begin
      wbuf[0] = 8'(len);
      block_write(8'd6, 8'd1, 1);
      block_read(8'd0, len + 2);
      check("R4 length byte", rbuf[0], 8'(len));
      for (int k = 1; k <= len + 2; k++) begin
        if (k <= len) begin
          if (k - 1 == 4 || k - 1 == 5)
            check("R7 id register read", rbuf[k], model[k - 1]);
          else if (k - 1 == 3 || k - 1 >= 7)
            check("R8 unimplemented reads zero", rbuf[k], 8'h00);
          else
            check("R4 data byte", rbuf[k], model[k - 1]);
        end else begin
          check("R4 fill beyond length", rbuf[k], 8'hFF);
        end
      end
    end

    // R4 read from a nonzero index
    wbuf[0] = 8'd3;
    block_write(8'd6, 8'd1, 1);
    block_read(8'd4, 3);
    check("R4 offset length", rbuf[0], 8'd3);
    check("R7 revision/vendor", rbuf[1], {REV, 4'b0001});
    check("R7 device id", rbuf[2], DEV);
    check("R4 offset data at index 6", rbuf[3], 8'd3);

    // R3 bytes beyond the count
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    block_write(8'd1, 8'd1, 2);
    check("R3 first byte acked", {7'd0, abuf[3]}, 8'h01);
    check("R3 extra byte not acked", {7'd0, abuf[4]}, 8'h00);
    check_ports("R3 extra byte not stored");

    // R9 stop inside a data byte
    bus_start();
    wr_byte(8'hDC, a); wr_byte(8'd1, a); wr_byte(8'd2, a);
    wr_byte(8'h11, a);
    model[1] = 8'h11;
    send_bits(8'h0F, 4);
    bus_stop();
    check_ports("R9 stop mid byte");

    // R9 repeated start inside a byte, then a clean write
    bus_start();
    wr_byte(8'hDC, a); wr_byte(8'd2, a); wr_byte(8'd1, a);
    send_bits(8'hF0, 5);
    bus_start();
    wr_byte(8'hDC, a); wr_byte(8'd2, a); wr_byte(8'd1, a);
    wr_byte(8'h96, a);
    bus_stop();
    model[2] = 8'h96;
    check_ports("R9 restart mid byte");

    check("R10 drive moved while clock high", 8'(viol), 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule